// File: doc/BRIEF.md
# Conditional Control-Transfer Gate

This block sits beside the decoder of a stack processor and decides, one instruction at a time, where the program counter goes next for the indirect transfers. It owns the condition prefix: when a condition opcode arrives, the block tests a data-stack cell against a sign, zero and carry mask and compares the result with a polarity bit. It then holds the outcome as a pending condition. The next transfer instruction (jump through the data stack, call through the data stack, return, or coroutine switch) is taken or suppressed according to that pending outcome. A transfer with no prefix in front of it is always taken.

A separate one-byte modifier prefix redirects the following condition test from the top data cell to the second cell. The block does not own the stacks. It raises pop and push requests for both stacks and supplies the return address to push. The surrounding core applies those requests and presents the updated stack cells on the following cycle. Direct-displacement branches and instruction fetch are handled elsewhere. An opcode slot with the valid input low holds the program counter and changes no state.

Top module: `cflow_gate`

## Requirements
- R1: After reset no condition and no modifier is pending, so the first transfer is taken unconditionally.
- R2: A condition opcode has bit 7 = 0 and bits 3:1 = 100. Its mask bits are neg = bit 6, zero = bit 5 and carry = bit 4, and its polarity is bit 0. The outcome is true when ((cell bit CELL_W-1 AND neg) OR (cell == 0 AND zero) OR (carry_flag AND carry)) equals the polarity. Examples: 0x08 always, 0x09 never, 0x29 cell is zero, 0x49 cell is negative.
- R3: Without a pending modifier, a condition pops and tests the top data cell (d_pop_top). After the modifier 0xC0, it removes and tests the second cell (d_pop_sec) and leaves the top cell in place.
- R4: Jump-indirect 0x40 always requests a data pop. It loads pc_next from d_top only when the gate is open.
- R5: Return 0x60 always requests a return-stack pop. It loads pc_next from r_top only when the gate is open.
- R6: Call-indirect 0x50 with the gate closed raises no requests. With the gate open it pops the data stack, pushes pc_cur+1 onto the return stack and loads pc_next from d_top.
- R7: Switch 0x70 with the gate closed raises no requests. With the gate open it pops and pushes the return stack together (push value pc_cur+1) and loads pc_next from r_top.
- R8: A pending condition gates only the next transfer. The transfer clears it, and so does any other valid instruction except the modifier 0xC0, which keeps it pending.
- R9: The carry term uses carry_flag as it is in the cycle of the condition opcode. The carry value at the transfer has no effect.
- R10: Every other valid opcode yields pc_next = pc_cur+1 with no stack request. With op_vld low, pc_next = pc_cur, no request is raised and no state changes.
- R11: xfer_taken is high exactly when pc_next is loaded from a stack cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Opcode slot valid |
| op_byte | input | 8 | Decoded opcode |
| d_top | input | CELL_W | Top data-stack cell |
| d_sec | input | CELL_W | Second data-stack cell |
| r_top | input | CELL_W | Top return-stack cell |
| pc_cur | input | PC_W | Address of the current opcode |
| carry_flag | input | 1 | Carry flag |
| pc_next | output | PC_W | Next program counter |
| xfer_taken | output | 1 | Transfer loads the PC from a stack cell |
| d_pop_top | output | 1 | Pop the top data cell |
| d_pop_sec | output | 1 | Remove the second data cell |
| r_pop | output | 1 | Pop the return stack |
| r_push | output | 1 | Push onto the return stack |
| r_push_data | output | CELL_W | Value to push (pc_cur+1) |

## Verification
The hardest situations to reach are the interleavings of prefixes. Examples are a modifier placed between a condition and its transfer, a condition followed by an unrelated opcode and then a transfer, and a carry that changes between the condition and the transfer. Directed sequences build each of these explicitly. A long random run then draws opcodes from a pool weighted toward prefixes and transfers. The random run also draws stack cells that are often zero or negative, so both polarities of every mask term occur many times.

// File: rtl/cflow_pkg.sv
package cflow_pkg;

   localparam logic [7:0] OP_MODSEC = 8'hC0;
   localparam logic [7:0] OP_JMP_D  = 8'h40;
   localparam logic [7:0] OP_CALL_D = 8'h50;
   localparam logic [7:0] OP_RET_R  = 8'h60;
   localparam logic [7:0] OP_SWAP_R = 8'h70;

   typedef enum logic [2:0] {
      XK_NONE,
      XK_JUMP_D,
      XK_CALL_D,
      XK_RET_R,
      XK_SWAP_R
   } xfer_kind_e;

   typedef struct packed {
      logic neg_en;
      logic zero_en;
      logic cy_en;
      logic pol;
   } cond_sel_t;

   function automatic logic is_cond_op(input logic [7:0] op);
      return (op[7] == 1'b0) && (op[3:1] == 3'b100);
   endfunction

   function automatic cond_sel_t cond_fields(input logic [7:0] op);
      cond_sel_t s;
      s.neg_en  = op[6];
      s.zero_en = op[5];
      s.cy_en   = op[4];
      s.pol     = op[0];
      return s;
   endfunction

   function automatic xfer_kind_e xfer_kind(input logic [7:0] op);
      case (op)
         OP_JMP_D:  return XK_JUMP_D;
         OP_CALL_D: return XK_CALL_D;
         OP_RET_R:  return XK_RET_R;
         OP_SWAP_R: return XK_SWAP_R;
         default:   return XK_NONE;
      endcase
   endfunction

endpackage

// File: rtl/cflow_cond_eval.sv
module cflow_cond_eval
   import cflow_pkg::*;
#(
   parameter int CELL_W     = 64,
   parameter int ZERO_CHUNK = 8
) (
   input  logic [CELL_W-1:0] value,
   input  cond_sel_t         sel,
   input  logic              carry,
   output logic              hit
);

   logic is_zero;
   logic term;

   generate
      if (ZERO_CHUNK <= 0 || ZERO_CHUNK >= CELL_W) begin : g_flat_zero
         assign is_zero = (value == '0);
      end else begin : g_chunk_zero
         localparam int NCH  = (CELL_W + ZERO_CHUNK - 1) / ZERO_CHUNK;
         localparam int PADW = NCH * ZERO_CHUNK;
         logic [PADW-1:0] padded;
         logic [NCH-1:0]  chunk_nz;
         assign padded = PADW'(value);
         for (genvar g = 0; g < NCH; g++) begin : g_chunk
            assign chunk_nz[g] = |padded[g*ZERO_CHUNK +: ZERO_CHUNK];
         end
         assign is_zero = ~|chunk_nz;
      end
   endgenerate

   assign term = (value[CELL_W-1] & sel.neg_en)
               | (is_zero          & sel.zero_en)
               | (carry            & sel.cy_en);
   assign hit  = ~(term ^ sel.pol);

endmodule

// File: rtl/cflow_prefix_state.sv
module cflow_prefix_state (
   input  logic clk,
   input  logic rst_n,
   input  logic op_vld,
   input  logic op_cond,
   input  logic op_sec,
   input  logic cond_hit,
   output logic armed,
   output logic armed_ok,
   output logic sec_armed
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         armed_ok  <= 1'b0;
         sec_armed <= 1'b0;
      end else if (op_vld) begin
         if (op_sec) begin
            sec_armed <= 1'b1;
         end else begin
            sec_armed <= 1'b0;
            armed     <= op_cond;
            armed_ok  <= op_cond & cond_hit;
         end
      end
   end

endmodule

// File: rtl/cflow_xfer_decode.sv
module cflow_xfer_decode
   import cflow_pkg::*;
#(
   parameter int CELL_W = 64,
   parameter int PC_W   = 32
) (
   input  logic              op_vld,
   input  logic [7:0]        op_byte,
   input  logic              op_cond,
   input  logic              armed,
   input  logic              armed_ok,
   input  logic              sec_armed,
   input  logic [PC_W-1:0]   d_tgt,
   input  logic [PC_W-1:0]   r_tgt,
   input  logic [PC_W-1:0]   pc_cur,
   output logic [PC_W-1:0]   pc_next,
   output logic              xfer_taken,
   output logic              d_pop_top,
   output logic              d_pop_sec,
   output logic              r_pop,
   output logic              r_push,
   output logic [CELL_W-1:0] r_push_data
);

   logic [PC_W-1:0] pc_inc;
   logic            gate_ok;
   xfer_kind_e      kind;

   assign pc_inc      = pc_cur + PC_W'(1);
   assign gate_ok     = ~armed | armed_ok;
   assign kind        = xfer_kind(op_byte);
   assign r_push_data = CELL_W'(pc_inc);

   always_comb begin
      pc_next    = op_vld ? pc_inc : pc_cur;
      xfer_taken = 1'b0;
      d_pop_top  = 1'b0;
      d_pop_sec  = 1'b0;
      r_pop      = 1'b0;
      r_push     = 1'b0;
      if (op_vld) begin
         if (op_cond) begin
            d_pop_sec = sec_armed;
            d_pop_top = ~sec_armed;
         end
         case (kind)
            XK_JUMP_D: begin
               d_pop_top = 1'b1;
               if (gate_ok) begin
                  xfer_taken = 1'b1;
                  pc_next    = d_tgt;
               end
            end
            XK_CALL_D: begin
               if (gate_ok) begin
                  d_pop_top  = 1'b1;
                  r_push     = 1'b1;
                  xfer_taken = 1'b1;
                  pc_next    = d_tgt;
               end
            end
            XK_RET_R: begin
               r_pop = 1'b1;
               if (gate_ok) begin
                  xfer_taken = 1'b1;
                  pc_next    = r_tgt;
               end
            end
            XK_SWAP_R: begin
               if (gate_ok) begin
                  r_pop      = 1'b1;
                  r_push     = 1'b1;
                  xfer_taken = 1'b1;
                  pc_next    = r_tgt;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/cflow_gate.sv
module cflow_gate
   import cflow_pkg::*;
#(
   parameter int CELL_W     = 64,
   parameter int PC_W       = 32,
   parameter int ZERO_CHUNK = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_vld,
   input  logic [7:0]        op_byte,
   input  logic [CELL_W-1:0] d_top,
   input  logic [CELL_W-1:0] d_sec,
   input  logic [CELL_W-1:0] r_top,
   input  logic [PC_W-1:0]   pc_cur,
   input  logic              carry_flag,
   output logic [PC_W-1:0]   pc_next,
   output logic              xfer_taken,
   output logic              d_pop_top,
   output logic              d_pop_sec,
   output logic              r_pop,
   output logic              r_push,
   output logic [CELL_W-1:0] r_push_data
);

   generate
      if (CELL_W < 16) begin : g_bad_cell
         $error("cflow_gate: CELL_W must be at least 16");
      end
      if (PC_W < 2 || PC_W > CELL_W) begin : g_bad_pc
         $error("cflow_gate: PC_W must lie in 2..CELL_W");
      end
   endgenerate

   logic              op_cond;
   logic              op_sec;
   logic              cond_hit;
   logic              armed;
   logic              armed_ok;
   logic              sec_armed;
   logic [CELL_W-1:0] cond_value;
   logic              unused_hi_bits;

   assign op_cond        = is_cond_op(op_byte);
   assign op_sec         = (op_byte == OP_MODSEC);
   assign cond_value     = sec_armed ? d_sec : d_top;
   assign unused_hi_bits = ^{d_top, r_top};

   cflow_cond_eval #(
      .CELL_W     (CELL_W),
      .ZERO_CHUNK (ZERO_CHUNK)
   ) u_eval (
      .value (cond_value),
      .sel   (cond_fields(op_byte)),
      .carry (carry_flag),
      .hit   (cond_hit)
   );

   cflow_prefix_state u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_vld    (op_vld),
      .op_cond   (op_cond),
      .op_sec    (op_sec),
      .cond_hit  (cond_hit),
      .armed     (armed),
      .armed_ok  (armed_ok),
      .sec_armed (sec_armed)
   );

   cflow_xfer_decode #(
      .CELL_W (CELL_W),
      .PC_W   (PC_W)
   ) u_xfer (
      .op_vld      (op_vld),
      .op_byte     (op_byte),
      .op_cond     (op_cond),
      .armed       (armed),
      .armed_ok    (armed_ok),
      .sec_armed   (sec_armed),
      .d_tgt       (d_top[PC_W-1:0]),
      .r_tgt       (r_top[PC_W-1:0]),
      .pc_cur      (pc_cur),
      .pc_next     (pc_next),
      .xfer_taken  (xfer_taken),
      .d_pop_top   (d_pop_top),
      .d_pop_sec   (d_pop_sec),
      .r_pop       (r_pop),
      .r_push      (r_push),
      .r_push_data (r_push_data)
   );

endmodule

// File: rtl/cflow_gate_chk.sv
module cflow_gate_chk
   import cflow_pkg::*;
#(
   parameter int CELL_W = 64,
   parameter int PC_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_vld,
   input logic [7:0]        op_byte,
   input logic [PC_W-1:0]   pc_cur,
   input logic [PC_W-1:0]   pc_next,
   input logic              xfer_taken,
   input logic              d_pop_top,
   input logic              d_pop_sec,
   input logic              r_pop,
   input logic              r_push,
   input logic [CELL_W-1:0] r_push_data
);

   logic live;
   always_ff @(posedge clk) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   AST_POP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(d_pop_top && d_pop_sec)); // R3

   AST_JUMP_POPS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && op_byte == OP_JMP_D) |-> d_pop_top); // R4

   AST_RET_POPS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && op_byte == OP_RET_R) |-> r_pop); // R5

   AST_CALL_SHUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && op_byte == OP_CALL_D && !xfer_taken) |-> (!d_pop_top && !r_push)); // R6

   AST_PUSH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      r_push |-> (r_push_data == CELL_W'(pc_cur + PC_W'(1)))); // R7

   AST_CLEARED_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op_vld && op_byte == OP_JMP_D &&
       $past(op_vld && !is_cond_op(op_byte) && op_byte != OP_MODSEC)) |-> xfer_taken); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !op_vld |-> (pc_next == pc_cur && !xfer_taken && !d_pop_top && !d_pop_sec
                   && !r_pop && !r_push)); // R10

   AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && !xfer_taken) |-> (pc_next == pc_cur + PC_W'(1))); // R11

endmodule

bind cflow_gate cflow_gate_chk #(.CELL_W(CELL_W), .PC_W(PC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_vld      (op_vld),
   .op_byte     (op_byte),
   .pc_cur      (pc_cur),
   .pc_next     (pc_next),
   .xfer_taken  (xfer_taken),
   .d_pop_top   (d_pop_top),
   .d_pop_sec   (d_pop_sec),
   .r_pop       (r_pop),
   .r_push      (r_push),
   .r_push_data (r_push_data)
);

// File: tb/cflow_gate_test.sv
module cflow_gate_test;

   localparam int W  = 64;
   localparam int PW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_vld = 1'b0;
   logic [7:0]    op_byte = 8'h00;
   logic [W-1:0]  d_top = '0;
   logic [W-1:0]  d_sec = '0;
   logic [W-1:0]  r_top = '0;
   logic [PW-1:0] pc_cur = '0;
   logic          carry_flag = 1'b0;
   logic [PW-1:0] pc_next;
   logic          xfer_taken, d_pop_top, d_pop_sec, r_pop, r_push;
   logic [W-1:0]  r_push_data;

   int checks = 0;
   int bad = 0;
   bit done = 0;

   bit m_armed = 0;
   bit m_ok = 0;
   bit m_sec = 0;

   always #5 clk = ~clk;

   cflow_gate uut (
      .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_byte(op_byte),
      .d_top(d_top), .d_sec(d_sec), .r_top(r_top), .pc_cur(pc_cur),
      .carry_flag(carry_flag), .pc_next(pc_next), .xfer_taken(xfer_taken),
      .d_pop_top(d_pop_top), .d_pop_sec(d_pop_sec), .r_pop(r_pop),
      .r_push(r_push), .r_push_data(r_push_data)
   );

   task automatic step(input bit vld, input logic [7:0] op, input logic [W-1:0] dt,
                       input logic [W-1:0] ds, input logic [W-1:0] rt,
                       input logic [PW-1:0] pc, input bit cy, input string tag);
      logic [PW-1:0] e_pc;
      bit e_tk, e_dp, e_ds, e_rp, e_ru, isc, hit, open, term;
      logic [W-1:0] val;
      @(negedge clk);
      op_vld = vld; op_byte = op; d_top = dt; d_sec = ds; r_top = rt;
      pc_cur = pc; carry_flag = cy;
      #1;
      e_pc = vld ? pc + 1 : pc;
      e_tk = 0; e_dp = 0; e_ds = 0; e_rp = 0; e_ru = 0; hit = 0;
      isc = (op[7] == 0) && (op[3:1] == 3'b100);
      open = !m_armed || m_ok;
      if (vld) begin
         if (isc) begin
            val = m_sec ? ds : dt;
            term = (val[W-1] && op[6]) || (val == 0 && op[5]) || (cy && op[4]);
            hit = (term == op[0]);
            if (m_sec) e_ds = 1; else e_dp = 1;
         end
         if (op == 8'h40) begin
            e_dp = 1;
            if (open) begin e_tk = 1; e_pc = dt[PW-1:0]; end
         end else if (op == 8'h50) begin
            if (open) begin e_dp = 1; e_ru = 1; e_tk = 1; e_pc = dt[PW-1:0]; end
         end else if (op == 8'h60) begin
            e_rp = 1;
            if (open) begin e_tk = 1; e_pc = rt[PW-1:0]; end
         end else if (op == 8'h70) begin
            if (open) begin e_rp = 1; e_ru = 1; e_tk = 1; e_pc = rt[PW-1:0]; end
         end
      end
      checks++;
      if (pc_next !== e_pc || xfer_taken !== e_tk || d_pop_top !== e_dp ||
          d_pop_sec !== e_ds || r_pop !== e_rp || r_push !== e_ru ||
          (e_ru && r_push_data !== W'(pc + 1))) begin
         bad++;
         $display("FAIL %s op=%h: got pc=%h tk=%b dp=%b ds=%b rp=%b ru=%b rd=%h exp pc=%h tk=%b dp=%b ds=%b rp=%b ru=%b rd=%h",
                  tag, op, pc_next, xfer_taken, d_pop_top, d_pop_sec, r_pop, r_push,
                  r_push_data, e_pc, e_tk, e_dp, e_ds, e_rp, e_ru, W'(pc + 1));
      end
      if (vld) begin
         if (op == 8'hC0) m_sec = 1;
         else begin
            m_sec = 0;
            m_armed = isc;
            m_ok = isc && hit;
         end
      end
   endtask

   localparam logic [W-1:0] NEG = 64'hF000_0000_0000_0123;

   initial begin
      logic [7:0] pool [16];
      pool = '{8'h08, 8'h09, 8'h29, 8'h49, 8'h19, 8'h28, 8'h68, 8'h39,
               8'hC0, 8'hC0, 8'h40, 8'h50, 8'h60, 8'h70, 8'h02, 8'h15};
      repeat (3) @(negedge clk);
      rst_n = 1;
      step(1, 8'h40, 64'h100, 0, 64'h900, 32'h10, 0, "R1 jump after reset");
      step(1, 8'h09, 64'h5, 0, 0, 32'h11, 0, "R2 never prefix");
      step(1, 8'h40, 64'h200, 0, 0, 32'h12, 0, "R4 jump shut");
      step(1, 8'h08, 64'h5, 0, 0, 32'h13, 0, "R2 always prefix");
      step(1, 8'h40, 64'h300, 0, 0, 32'h14, 0, "R4 jump open");
      step(1, 8'h29, 64'h0, 0, 0, 32'h20, 0, "R2 zero test true");
      step(1, 8'h60, 0, 0, 64'h444, 32'h21, 0, "R5 ret open");
      step(1, 8'h29, 64'h7, 0, 0, 32'h22, 0, "R2 zero test false");
      step(1, 8'h60, 0, 0, 64'h555, 32'h23, 0, "R5 ret shut");
      step(1, 8'h49, NEG, 0, 0, 32'h24, 0, "R2 negative test");
      step(1, 8'h50, 64'h777, 0, 0, 32'h25, 0, "R6 call open");
      step(1, 8'h09, 1, 0, 0, 32'h26, 0, "R2 never prefix");
      step(1, 8'h50, 64'h777, 0, 0, 32'h27, 0, "R6 call shut");
      step(1, 8'hC0, 64'h7, 0, 0, 32'h30, 0, "R3 modifier");
      step(1, 8'h29, 64'h7, 64'h0, 0, 32'h31, 0, "R3 second cell tested");
      step(1, 8'h40, 64'h7, 0, 0, 32'h32, 0, "R3 jump after second test");
      step(1, 8'h29, 64'h0, 0, 0, 32'h33, 0, "R7 prefix true");
      step(1, 8'h70, 0, 0, 64'h1234, 32'h34, 0, "R7 switch open");
      step(1, 8'h09, 0, 0, 0, 32'h35, 0, "R7 prefix false");
      step(1, 8'h70, 0, 0, 64'h1234, 32'h36, 0, "R7 switch shut");
      step(1, 8'h09, 0, 0, 0, 32'h40, 0, "R8 never prefix");
      step(1, 8'h02, 0, 0, 0, 32'h41, 0, "R10 plain opcode");
      step(1, 8'h40, 64'h88, 0, 0, 32'h42, 0, "R8 gate cleared");
      step(1, 8'h09, 0, 0, 0, 32'h43, 0, "R8 never prefix");
      step(1, 8'hC0, 0, 0, 0, 32'h44, 0, "R8 modifier keeps gate");
      step(1, 8'h40, 64'h99, 0, 0, 32'h45, 0, "R8 still shut");
      step(1, 8'h19, 1, 0, 0, 32'h50, 1, "R9 carry sampled");
      step(1, 8'h40, 64'hAA, 0, 0, 32'h51, 0, "R9 carry ignored at jump");
      step(0, 8'h40, 64'hBB, 0, 0, 32'h52, 1, "R10 idle slot");
      step(1, 8'h40, 64'hCC, 0, 0, 32'h53, 0, "R11 taken");
      step(1, 8'hC0, 0, 0, 0, 32'hFFFF_FFFF, 0, "R11 pc wrap");
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] a, b;
         a = ($urandom % 3 == 0) ? '0 : {$urandom, $urandom};
         b = ($urandom % 3 == 0) ? '0 : {$urandom, $urandom};
         step(($urandom % 8) != 0, pool[$urandom % 16], a, b, {$urandom, $urandom},
              $urandom, $urandom % 2, "R11 random");
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule